// File: doc/BRIEF.md
# Triggered Serial Byte Capture with Packed-BCD to Binary Conversion

This block waits for a rising edge on a trigger level and then collects a burst of serial data bits, one per system clock, into a capture word. The first bit of the burst goes into the least significant position. When the word is complete, the block stops listening. Serial traffic that follows is dropped until the trigger goes low and then high again. The completed word holds two packed decimal digits. The block turns them into a binary number with shifts and adds only, and announces the new number with a one-cycle strobe.

The trigger is treated as plain data. It is registered on the system clock and compared with its previous value, and it never clocks anything. The control is a two-state machine. S_WAIT is the idle state, with the bit counter held at zero. S_SHIFT is the state that collects bits. The transitions are:
- ARM: S_WAIT to S_SHIFT on a trigger rise.
- RESTART: S_SHIFT to S_SHIFT on a trigger rise, which throws away the partial word and starts again at bit 0.
- STEP: S_SHIFT to S_SHIFT on an ordinary bit that is not the last.
- FINISH: S_SHIFT to S_WAIT when the last bit is taken.

Top module: `trig_bcd_receiver`

## Requirements
- R1: A capture is armed only when the trigger is sampled low at one clock edge and high at the next. A trigger held high, including one held high while reset is released, arms nothing.
- R2: The serial bit sampled at the clock edge where the rise is recognised is stored as bit 0. The bits at the following edges fill bits 1 to 7 in order. Bits 7:4 form the upper decimal digit and bits 3:0 the lower digit.
- R3: Exactly 8 bits are taken per capture. After that, the block idles with its counter at zero, and further serial bits change neither the result nor the strobe.
- R4: A trigger rise after a completed capture starts a new capture, and a new result is delivered.
- R5: A trigger rise during a capture, including at the edge that would take the last bit, restarts the capture at bit 0. The partial word produces no strobe.
- R6: `valid_o` is high for exactly one clock: the cycle after the edge that takes the 8th bit. It is low at all other times.
- R7: `result_o` equals upper digit times ten plus lower digit. Digits above 9 are computed arithmetically, so 0xFF gives 165 and 0x9A gives 100. The value holds until the next strobe.
- R8: A synchronous reset clears `result_o` to 0 and `valid_o` to 0, and abandons any capture in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data bit, one per clock |
| trig_in | input | 1 | Trigger level; its rising edge arms a capture |
| result_o | output | 8 | Binary value of the last completed word |
| valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The hardest situation to reach is a restart at the very edge that would otherwise complete the word. There, the restart must take priority over completion, and no strobe may escape. The stimulus reaches it by arming a capture and dropping the trigger for the middle bits. It then raises the trigger again exactly when the counter stands at its last index, and feeds a fresh word whose expected value differs from the partial one. A second hard case is a trigger held high across reset release. It is covered by asserting reset mid-capture and releasing it with the trigger still high, while random bits keep arriving.

// File: rtl/trig_cap_pkg.sv
package trig_cap_pkg;

    localparam int DEF_NIB_W = 4;

    typedef enum logic {
        S_WAIT  = 1'b0,
        S_SHIFT = 1'b1
    } cap_state_e;

endpackage

// File: rtl/trig_rise_det.sv
module trig_rise_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic rise_o
);
    // Previous level resets high so a level already high at reset release
    // is not mistaken for a fresh rise.
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b1;
        else     lvl_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~lvl_q;

    // R1: a rise needs the level to have been low at the previous edge
    p_rise_after_low_r1: assert property (@(posedge clk) disable iff (rst)
        rise_o |-> !$past(lvl_i));

endmodule

// File: rtl/bcd_pair_to_bin.sv
module bcd_pair_to_bin #(
    parameter int NIB_W = 4,
    parameter int BIN_W = 8
) (
    input  logic [2*NIB_W-1:0] word_i,
    output logic [BIN_W-1:0]   bin_o
);
    logic [BIN_W-1:0] hi_ext;
    logic [BIN_W-1:0] lo_ext;

    assign hi_ext = BIN_W'(word_i[2*NIB_W-1:NIB_W]);
    assign lo_ext = BIN_W'(word_i[NIB_W-1:0]);

    // times ten as eight plus two, no multiplier
    assign bin_o = (hi_ext << 3) + (hi_ext << 1) + lo_ext;

endmodule

// File: rtl/serial_cap_fsm.sv
module serial_cap_fsm
    import trig_cap_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_i,
    input  logic              rise_i,
    output logic [WORD_W-1:0] word_nxt_o,
    output logic              done_o
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    cap_state_e        state_q, state_n;
    logic [CNT_W-1:0]  cnt_q,   cnt_n;
    logic [WORD_W-1:0] word_q,  word_n;
    logic              done_n;

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        word_n  = word_q;
        done_n  = 1'b0;
        if (rise_i) begin
            // ARM from S_WAIT, RESTART from S_SHIFT
            word_n    = '0;
            word_n[0] = ser_i;
            cnt_n     = CNT_W'(1);
            state_n   = S_SHIFT;
        end else begin
            unique case (state_q)
                S_WAIT: begin
                    cnt_n = '0;
                end
                S_SHIFT: begin
                    word_n[cnt_q] = ser_i;
                    if (cnt_q == LAST_IDX) begin
                        // FINISH
                        cnt_n   = '0;
                        state_n = S_WAIT;
                        done_n  = 1'b1;
                    end else begin
                        // STEP
                        cnt_n = cnt_q + CNT_W'(1);
                    end
                end
                default: begin
                    state_n = S_WAIT;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_WAIT;
            cnt_q   <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            word_q  <= word_n;
        end
    end

    assign word_nxt_o = word_n;
    assign done_o     = done_n;

    // R3: idle means the counter rests at zero
    p_idle_cnt_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_WAIT) |-> (cnt_q == '0));

    // R3: completing a word always returns to idle
    p_done_to_idle_r3: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (state_q == S_WAIT));

    // R5: any rise restarts collection with bit 0 already taken
    p_restart_r5: assert property (@(posedge clk) disable iff (rst)
        rise_i |=> (state_q == S_SHIFT && cnt_q == CNT_W'(1)));

    // R5: a rise never coincides with completion
    p_rise_blocks_done_r5: assert property (@(posedge clk) disable iff (rst)
        rise_i |-> !done_o);

endmodule

// File: rtl/trig_bcd_receiver.sv
module trig_bcd_receiver
    import trig_cap_pkg::*;
#(
    parameter  int NIB_W  = DEF_NIB_W,
    localparam int WORD_W = 2 * NIB_W,
    localparam int CNT_W  = $clog2(WORD_W),
    localparam int BIN_W  = $clog2(((2 ** NIB_W) - 1) * 11 + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_in,
    input  logic             trig_in,
    output logic [BIN_W-1:0] result_o,
    output logic             valid_o
);
    logic              rise;
    logic [WORD_W-1:0] word_nxt;
    logic              done;
    logic [BIN_W-1:0]  bin;

    trig_rise_det i_rise (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (trig_in),
        .rise_o (rise)
    );

    serial_cap_fsm #(
        .WORD_W (WORD_W),
        .CNT_W  (CNT_W)
    ) i_fsm (
        .clk        (clk),
        .rst        (rst),
        .ser_i      (ser_in),
        .rise_i     (rise),
        .word_nxt_o (word_nxt),
        .done_o     (done)
    );

    bcd_pair_to_bin #(
        .NIB_W (NIB_W),
        .BIN_W (BIN_W)
    ) i_conv (
        .word_i (word_nxt),
        .bin_o  (bin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= done;
            if (done) result_o <= bin;
        end
    end

    // R6: strobe lasts one cycle
    p_valid_single_r6: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R7: result only moves together with the strobe
    p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(result_o));

endmodule

// File: tb/test_trig_bcd_receiver.sv
module test_trig_bcd_receiver;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_in = 1'b0;
    logic       trig_in = 1'b0;
    logic [7:0] result_o;
    logic       valid_o;

    int checks = 0;
    int errors = 0;
    int exp_res = 0;
    bit finished = 1'b0;

    trig_bcd_receiver i_trig_bcd_receiver (
        .clk      (clk),
        .rst      (rst),
        .ser_in   (ser_in),
        .trig_in  (trig_in),
        .result_o (result_o),
        .valid_o  (valid_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int bcd_val(input logic [7:0] w);
        return int'(w[7:4]) * 10 + int'(w[3:0]);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Full capture of word w, bit 0 first; checks strobe timing and value.
    task automatic capture(input logic [7:0] w, input string req);
        @(negedge clk);
        trig_in = 1'b0;
        ser_in  = 1'($urandom);
        check(valid_o == 1'b0, "R5/R6 no strobe before capture", int'(valid_o), 0);
        @(negedge clk);
        trig_in = 1'b1;
        ser_in  = w[0];
        for (int k = 1; k < 8; k++) begin
            @(negedge clk);
            check(valid_o == 1'b0, "R6 strobe early", int'(valid_o), 0);
            ser_in = w[k];
        end
        @(negedge clk);
        exp_res = bcd_val(w);
        check(valid_o == 1'b1, {req, " R6 strobe"}, int'(valid_o), 1);
        check(int'(result_o) == exp_res, {req, " R7 value"}, int'(result_o), exp_res);
        ser_in = 1'($urandom);
        @(negedge clk);
        check(valid_o == 1'b0, "R6 single cycle", int'(valid_o), 0);
    endtask

    // Arm and feed n bits, trigger low after the first one.
    task automatic partial(input int n);
        @(negedge clk);
        trig_in = 1'b0;
        @(negedge clk);
        trig_in = 1'b1;
        ser_in  = 1'($urandom);
        for (int k = 1; k < n; k++) begin
            @(negedge clk);
            trig_in = 1'b0;
            ser_in  = 1'($urandom);
        end
    endtask

    // Keep trigger as is and toggle data; nothing may change.
    task automatic quiet(input int cycles, input string req);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            ser_in = 1'($urandom);
            check(valid_o == 1'b0 && int'(result_o) == exp_res, req,
                  int'(result_o) + 256 * int'(valid_o), exp_res);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(valid_o == 1'b0, "R8 reset valid", int'(valid_o), 0);
        check(result_o == 8'd0, "R8 reset result", int'(result_o), 0);

        // R2 bit order and R7 arithmetic corners
        capture(8'h01, "R2 lsb first");
        capture(8'h80, "R2 msb last");
        capture(8'h59, "R2 digits");
        capture(8'hFF, "R7 ff");
        capture(8'h9A, "R7 9a");
        capture(8'h00, "R7 zero");

        // R3: trigger stays high, data keeps flowing, nothing happens
        quiet(20, "R3 ignored after capture");

        // R4: new trigger rise delivers new value
        capture(8'h37, "R4 rearm");

        // R5: restart early and at the last index
        partial(2);
        capture(8'h42, "R5 restart early");
        partial(6);
        capture(8'h86, "R5 restart at last bit");

        // R8: reset mid-capture, trigger held high across release (R1)
        partial(4);
        @(negedge clk);
        trig_in = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(valid_o == 1'b0, "R8 reset mid valid", int'(valid_o), 0);
        check(result_o == 8'd0, "R8 reset mid result", int'(result_o), 0);
        exp_res = 0;
        rst = 1'b0;
        quiet(12, "R1 held trigger arms nothing");

        // random captures
        for (int n = 0; n < 40; n++) begin
            logic [7:0] w;
            w = 8'($urandom);
            capture(w, "R7 random");
            if (($urandom % 4) == 0) quiet(3, "R3 random idle");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule